// File: doc/BRIEF.md
# Addressed Serial Register Port

This block is the slave side of a four-wire serial port (SCLK, DIN, DOUT, active-low select) in front of the register file of a multichannel converter. The host opens every access with a single command byte naming a register and a direction; the port then moves 8, 16 or 24 data bits, sized by the register addressed. Channel results from the converter core come in on a parallel bus and can be read singly or streamed as repeated status-plus-data frames for as long as the host keeps DIN low.

The serial inputs are brought into the system clock domain through synchronisers and edge detectors, so SCLK must be several times slower than `clk`. A run of one bits following a zero on DIN returns every register and the port's own state to defaults. With the select tied low, the port works as a three-wire link.

Top module: `ser_reg_port`

## Requirements
- R1: A transaction starts with a command byte, MSB first: bit 7 must be 0, bit 6 is 1 for a read and 0 for a write, bits 5:0 are the register address. A command byte with bit 7 set is dropped and the next byte is taken as a new command.
- R2: Register map (address: width, access, default): 01h: 8, read/write, 00h; 05h: 16, read/write, 0000h; 06h: 24, read/write, 800000h; 08h+n: 24, read-only, the live converter result of channel n; 20h+n: 8, read-only, 20h times n; 28h+n: 8, read/write, 00h; 30h+n: 8, read/write, 91h; n runs over 0 to 3.
- R3: DIN is sampled on each SCLK rising edge and DOUT changes only after SCLK falling edges, MSB first; the first read bit is driven after the first falling edge following the command byte's eighth rising edge.
- R4: A write to a read-only address is discarded after consuming its width; a write to an unmapped address, or to 38h+n, consumes 8 bits and is discarded; a read of an unmapped address returns 8 zero bits.
- R5: While cs_n is high, SCLK and DIN are ignored; raising cs_n abandons a partial transaction and the next selection expects a command byte.
- R6: dout_en is high exactly while the port is selected; dout is 0 outside read data bits and after reset.
- R7: A zero followed by 32 consecutive ones on DIN (counted on rising edges while selected) restores all registers to their defaults and returns the port to waiting for a command; a zero inside the run restarts the count.
- R8: A read command to 38h+n enters streaming: 32-bit frames of the status byte (20h times n) followed by the 24-bit result of channel n, the result being taken at the frame's start (the last rising edge before its first bit).
- R9: Streaming continues while DIN is low at the last rising edge of a frame; DIN high at that edge ends it, and the next byte is a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low port select |
| sclk | input | 1 | Serial clock from the host, idle high |
| din | input | 1 | Serial data from the host |
| conv_data | input | NCH*24 | Converter results, channel n in bits n*24 upward |
| dout | output | 1 | Serial data to the host |
| dout_en | output | 1 | Output enable for the DOUT pad driver |

## Verification
The hardest state to reach is the serial reset, because ordinary traffic can never hold DIN high for 32 rising edges: every valid command byte starts with a zero and no data field is wider than 24 bits. The stimulus builds the run from a write to an unmapped address whose 8-bit data is all ones, followed by three command bytes with bit 7 set, which the port drops. The same sequence with a trailing zero shows that a 31-bit run leaves a register unchanged. Stream capture timing is reached by changing one channel's result while the first frame is still shifting out, so the second frame must show the new value.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;

    localparam int WORD_W  = 24;
    localparam int FRAME_W = 32;
    localparam int CMD_W   = 8;

    localparam logic [5:0] A_IOP = 6'h01;
    localparam logic [5:0] A_CHK = 6'h05;
    localparam logic [5:0] A_ZSC = 6'h06;
    localparam logic [5:0] A_DAT = 6'h08;
    localparam logic [5:0] A_STA = 6'h20;
    localparam logic [5:0] A_SET = 6'h28;
    localparam logic [5:0] A_CTM = 6'h30;
    localparam logic [5:0] A_STR = 6'h38;

    localparam logic [23:0] ZSC_DEF  = 24'h800000;
    localparam logic [7:0]  CTM_DEF  = 8'h91;
    localparam logic [7:0]  STA_STEP = 8'h20;

    typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD, PH_STR} phase_e;

    typedef enum logic [3:0] {
        K_NONE, K_IOP, K_CHK, K_ZSC, K_DAT, K_STA, K_SET, K_CTM, K_STR
    } kind_e;

    typedef struct packed {
        logic       ext;
        logic       rnw;
        logic [5:0] addr;
    } cmd_t;

    function automatic logic in_bank(logic [5:0] a, logic [5:0] base, int nch);
        return (a[5:2] == base[5:2]) && (int'(a[1:0]) < nch);
    endfunction

    function automatic kind_e decode(logic [5:0] a, logic rnw, int nch);
        if (a == A_IOP)              return K_IOP;
        if (a == A_CHK)              return K_CHK;
        if (a == A_ZSC)              return K_ZSC;
        if (in_bank(a, A_DAT, nch))  return K_DAT;
        if (in_bank(a, A_STA, nch))  return K_STA;
        if (in_bank(a, A_SET, nch))  return K_SET;
        if (in_bank(a, A_CTM, nch))  return K_CTM;
        if (rnw && in_bank(a, A_STR, nch)) return K_STR;
        return K_NONE;
    endfunction

    function automatic int kind_bits(kind_e k);
        case (k)
            K_CHK:        return 16;
            K_ZSC, K_DAT: return WORD_W;
            K_STR:        return FRAME_W;
            default:      return 8;
        endcase
    endfunction

    function automatic logic kind_wr(kind_e k);
        return (k == K_IOP) || (k == K_CHK) || (k == K_ZSC) ||
               (k == K_SET) || (k == K_CTM);
    endfunction

    function automatic logic [7:0] sta_of(logic [1:0] ch);
        return 8'(STA_STEP * ch);
    endfunction

    // Left-justify a register value of the given width in a frame word.
    function automatic logic [FRAME_W-1:0] lalign(logic [WORD_W-1:0] w, int bits);
        case (bits)
            8:       return {w[7:0], 24'h0};
            16:      return {w[15:0], 16'h0};
            default: return {w, 8'h0};
        endcase
    endfunction

endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    input  logic din,
    output logic cs_act,
    output logic din_s,
    output logic rise,
    output logic fall
);
    localparam int         NSIG  = 3;
    localparam logic [2:0] RST_V = 3'b110;   // cs_n, sclk idle high; din low

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;
    logic            sclk_prev;

    assign raw = {cs_n, sclk, din};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        logic [STAGES-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) q <= {STAGES{RST_V[g]}};
            else     q <= {q[STAGES-2:0], raw[g]};
        end
        assign synced[g] = q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b1;
        else     sclk_prev <= synced[1];
    end

    assign cs_act = !synced[2];
    assign din_s  = synced[0];
    assign rise   = cs_act &&  synced[1] && !sclk_prev;
    assign fall   = cs_act && !synced[1] &&  sclk_prev;
endmodule

// File: rtl/ser_rst_detect.sv
module ser_rst_detect #(
    parameter int RUN = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic din,
    output logic hit
);
    localparam int CW = $clog2(RUN + 1);

    logic [CW-1:0] ones_q;

    assign hit = rise && din && (ones_q == CW'(RUN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_q <= '0;
        end else if (rise) begin
            if (!din || hit) ones_q <= '0;
            else             ones_q <= ones_q + 1'b1;
        end
    end
endmodule

// File: rtl/ser_regfile.sv
module ser_regfile
    import ser_reg_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  soft_rst,
    input  logic                  wr_en,
    input  kind_e                 wr_kind,
    input  logic [1:0]            wr_ch,
    input  logic [WORD_W-1:0]     wr_data,
    input  kind_e                 rd_kind,
    input  logic [1:0]            rd_ch,
    input  logic [NCH*WORD_W-1:0] conv_data,
    output logic [WORD_W-1:0]     rd_word
);
    logic [7:0]        iop_q;
    logic [15:0]       chk_q;
    logic [WORD_W-1:0] zsc_q;
    logic [7:0]        set_q [NCH];
    logic [7:0]        ctm_q [NCH];

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            iop_q <= '0;
            chk_q <= '0;
            zsc_q <= ZSC_DEF;
            for (int c = 0; c < NCH; c++) begin
                set_q[c] <= '0;
                ctm_q[c] <= CTM_DEF;
            end
        end else if (wr_en) begin
            case (wr_kind)
                K_IOP:   iop_q <= wr_data[7:0];
                K_CHK:   chk_q <= wr_data[15:0];
                K_ZSC:   zsc_q <= wr_data;
                K_SET:   set_q[wr_ch] <= wr_data[7:0];
                K_CTM:   ctm_q[wr_ch] <= wr_data[7:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_kind)
            K_IOP:   rd_word = {16'h0, iop_q};
            K_CHK:   rd_word = {8'h0, chk_q};
            K_ZSC:   rd_word = zsc_q;
            K_DAT:   rd_word = conv_data[int'(rd_ch)*WORD_W +: WORD_W];
            K_STA:   rd_word = {16'h0, sta_of(rd_ch)};
            K_SET:   rd_word = {16'h0, set_q[rd_ch]};
            K_CTM:   rd_word = {16'h0, ctm_q[rd_ch]};
            default: rd_word = '0;
        endcase
    end
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
    import ser_reg_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2,
    parameter int RESET_RUN   = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n,
    input  logic                  sclk,
    input  logic                  din,
    input  logic [NCH*WORD_W-1:0] conv_data,
    output logic                  dout,
    output logic                  dout_en
);
    localparam int CNT_W = $clog2(FRAME_W);

    logic              cs_act, din_s, rise, fall, soft_rst;
    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q, len_q;
    logic [WORD_W-1:0] rx_q;
    logic [FRAME_W-1:0] tx_q;
    logic              dout_q;
    kind_e             kind_q;
    logic [1:0]        ch_q;

    cmd_t              cmd;
    kind_e             cmd_kind;
    logic [WORD_W-1:0] rd_word;
    logic [FRAME_W-1:0] frame_new, frame_hold;
    logic              wr_en;
    logic [WORD_W-1:0] wr_data;

    ser_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .cs_act(cs_act), .din_s(din_s), .rise(rise), .fall(fall)
    );

    ser_rst_detect #(.RUN(RESET_RUN)) i_rdet (
        .clk(clk), .rst(rst), .rise(rise), .din(din_s), .hit(soft_rst)
    );

    // Command byte as it completes on the eighth rising edge.
    assign cmd      = cmd_t'({rx_q[CMD_W-2:0], din_s});
    assign cmd_kind = decode(cmd.addr, cmd.rnw, NCH);

    assign frame_new  = {sta_of(cmd.addr[1:0]),
                         conv_data[int'(cmd.addr[1:0])*WORD_W +: WORD_W]};
    assign frame_hold = {sta_of(ch_q), conv_data[int'(ch_q)*WORD_W +: WORD_W]};

    assign wr_data = {rx_q[WORD_W-2:0], din_s};
    assign wr_en   = rise && !soft_rst && (phase_q == PH_WR) &&
                     (cnt_q == len_q) && kind_wr(kind_q);

    ser_regfile #(.NCH(NCH)) i_regs (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .wr_en(wr_en), .wr_kind(kind_q), .wr_ch(ch_q), .wr_data(wr_data),
        .rd_kind(cmd_kind), .rd_ch(cmd.addr[1:0]),
        .conv_data(conv_data), .rd_word(rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            phase_q <= PH_CMD;
            cnt_q   <= '0;
            len_q   <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            dout_q  <= 1'b0;
            kind_q  <= K_NONE;
            ch_q    <= '0;
        end else if (!cs_act) begin
            phase_q <= PH_CMD;
            cnt_q   <= '0;
            dout_q  <= 1'b0;
        end else begin
            if (rise) begin
                rx_q  <= wr_data;
                cnt_q <= cnt_q + 1'b1;
                case (phase_q)
                    PH_CMD: begin
                        if (cnt_q == CNT_W'(CMD_W - 1)) begin
                            cnt_q <= '0;
                            if (!cmd.ext) begin
                                kind_q <= cmd_kind;
                                ch_q   <= cmd.addr[1:0];
                                len_q  <= CNT_W'(kind_bits(cmd_kind) - 1);
                                if (!cmd.rnw) begin
                                    phase_q <= PH_WR;
                                end else if (cmd_kind == K_STR) begin
                                    phase_q <= PH_STR;
                                    tx_q    <= frame_new;
                                end else begin
                                    phase_q <= PH_RD;
                                    tx_q    <= lalign(rd_word, kind_bits(cmd_kind));
                                end
                            end
                        end
                    end
                    PH_WR, PH_RD: begin
                        if (cnt_q == len_q) begin
                            phase_q <= PH_CMD;
                            cnt_q   <= '0;
                        end
                    end
                    PH_STR: begin
                        if (cnt_q == len_q) begin
                            cnt_q <= '0;
                            if (din_s) phase_q <= PH_CMD;
                            else       tx_q    <= frame_hold;
                        end
                    end
                    default: phase_q <= PH_CMD;
                endcase
            end
            if (fall) begin
                if (phase_q == PH_RD || phase_q == PH_STR) begin
                    dout_q <= tx_q[FRAME_W-1];
                    tx_q   <= {tx_q[FRAME_W-2:0], 1'b0};
                end else begin
                    dout_q <= 1'b0;
                end
            end
        end
    end

    assign dout    = dout_q;
    assign dout_en = cs_act;
endmodule

// File: rtl/ser_reg_port_chk.sv
module ser_reg_port_chk
    import ser_reg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cs_act,
    input logic       soft_rst,
    input phase_e     phase_q,
    input logic [4:0] cnt_q,
    input logic [4:0] len_q,
    input logic       wr_en,
    input logic       dout
);
    AST_CMD_COUNT: assert property (@(posedge clk) disable iff (rst)
        phase_q == PH_CMD |-> cnt_q < 5'd8);                              // R1

    AST_COUNT_IN_FIELD: assert property (@(posedge clk) disable iff (rst)
        phase_q != PH_CMD |-> cnt_q <= len_q);                            // R3

    AST_WRITE_ENDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> phase_q == PH_CMD);                                     // R4

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> phase_q == PH_CMD && cnt_q == 5'd0);                  // R5

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !dout);                                               // R6

    AST_SERIAL_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> phase_q == PH_CMD && !dout && !wr_en);               // R7

    AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (rst)
        phase_q == PH_STR |-> len_q == 5'd31);                            // R8
endmodule

bind ser_reg_port ser_reg_port_chk i_chk (
    .clk(clk), .rst(rst), .cs_act(cs_act), .soft_rst(soft_rst),
    .phase_q(phase_q), .cnt_q(cnt_q), .len_q(len_q),
    .wr_en(wr_en), .dout(dout)
);

// File: tb/test_ser_reg_port.sv
module test_ser_reg_port;
    localparam int NCH = 4;
    localparam int HP  = 8;    // SCLK half period in clk cycles

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b1;
    logic din  = 1'b0;
    logic [NCH*24-1:0] conv_data;
    logic dout, dout_en;

    int n_chk = 0, n_bad = 0, stab_bad = 0;
    bit done = 1'b0;

    logic [7:0]  m_iop;
    logic [15:0] m_chk;
    logic [23:0] m_zsc;
    logic [7:0]  m_set [NCH];
    logic [7:0]  m_ctm [NCH];

    always #5 clk = ~clk;

    ser_reg_port #(.NCH(NCH)) i_ser_reg_port (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .conv_data(conv_data), .dout(dout), .dout_en(dout_en)
    );

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            report();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_defaults();
        m_iop = 8'h00;
        m_chk = 16'h0000;
        m_zsc = 24'h800000;
        for (int c = 0; c < NCH; c++) begin
            m_set[c] = 8'h00;
            m_ctm[c] = 8'h91;
        end
    endtask

    function automatic int eb(input int a);
        if (a == 1) return 8;
        if (a == 5) return 16;
        if (a == 6 || (a >= 8 && a <= 11)) return 24;
        if (a >= 56 && a <= 59) return 32;
        return 8;
    endfunction

    function automatic logic [31:0] ev(input int a);
        if (a == 1) return {24'h0, m_iop};
        if (a == 5) return {16'h0, m_chk};
        if (a == 6) return {8'h0, m_zsc};
        if (a >= 8 && a <= 11) return {8'h0, conv_data[(a-8)*24 +: 24]};
        if (a >= 32 && a <= 35) return 32'((a - 32) * 32);
        if (a >= 40 && a <= 43) return {24'h0, m_set[a-40]};
        if (a >= 48 && a <= 51) return {24'h0, m_ctm[a-48]};
        if (a >= 56 && a <= 59) return {8'((a - 56) * 32), conv_data[(a-56)*24 +: 24]};
        return 32'h0;
    endfunction

    // One SCLK period: fall, drive DIN, sample DOUT just before the rise.
    task automatic bit_io(input logic b, output logic o);
        sclk = 1'b0;
        din  = b;
        wait_n(HP);
        o    = dout;
        sclk = 1'b1;
        wait_n(HP);
        if (dout !== o) stab_bad++;
    endtask

    task automatic shift(input logic [31:0] v, input int n, output logic [31:0] r);
        logic o;
        r = '0;
        for (int i = n - 1; i >= 0; i--) begin
            bit_io(v[i], o);
            r = {r[30:0], o};
        end
        din = 1'b0;
    endtask

    task automatic do_read(input int a, input string req);
        logic [31:0] r, j;
        shift({24'h0, 2'b01, 6'(a)}, 8, j);
        if (eb(a) == 32) shift(32'h1, 32, r);     // last bit high ends the stream
        else             shift(32'h0, eb(a), r);
        chk(r === ev(a), req, r, ev(a));
    endtask

    task automatic do_write(input int a, input logic [23:0] v);
        logic [31:0] j;
        int n;
        n = (eb(a) == 32) ? 8 : eb(a);
        shift({24'h0, 2'b00, 6'(a)}, 8, j);
        shift({8'h0, v}, n, j);
        if (a == 1) m_iop = v[7:0];
        if (a == 5) m_chk = v[15:0];
        if (a == 6) m_zsc = v;
        if (a >= 40 && a <= 43) m_set[a-40] = v[7:0];
        if (a >= 48 && a <= 51) m_ctm[a-48] = v[7:0];
    endtask

    task automatic read_sweep(input string req);
        for (int a = 0; a < 64; a++) do_read(a, req);
    endtask

    initial begin
        logic [31:0] r, j, exp1, exp2;
        logic o;
        conv_data = {24'h3C5A01, 24'h9E0F42, 24'h00FF7D, 24'hA51234};
        model_defaults();
        wait_n(6);
        chk(dout_en === 1'b0 && dout === 1'b0, "R6 reset outputs", {dout_en, dout}, 0);
        rst = 1'b0;
        wait_n(4);
        cs_n = 1'b0;
        wait_n(HP);
        chk(dout_en === 1'b1, "R6 enable while selected", dout_en, 1);

        // Defaults, unmapped zeros, stream frames with exit (R2 R4 R8 R9)
        read_sweep("R2 R4 R8 default sweep");

        // DOUT stays 0 while a command byte shifts in (R6)
        shift({24'h0, 8'h45}, 8, r);
        chk(r === 32'h0, "R6 dout low during command", r, 0);
        shift(32'h0, 16, r);
        chk(r === {16'h0, m_chk}, "R2 check register", r, m_chk);

        // Write every address, then read everything back (R2 R4)
        for (int a = 0; a < 64; a++)
            do_write(a, 24'((a * 24'h0B3D17) ^ 24'h5AC396));
        read_sweep("R2 R4 after write sweep");

        // MSB-first ordering (R3)
        do_write(5, 24'h008001);
        do_read(5, "R3 msb first 8001");

        // Command with bit 7 set is dropped (R1)
        shift({24'h0, 8'hC5}, 8, j);
        do_read(1, "R1 extended command ignored");

        // Deselected traffic ignored (R5, R6)
        cs_n = 1'b1;
        wait_n(HP);
        chk(dout_en === 1'b0, "R6 tri-state when deselected", dout_en, 0);
        shift({24'h0, 8'h01}, 8, j);
        shift({24'h0, 8'h3C}, 8, j);
        cs_n = 1'b0;
        wait_n(HP);
        do_read(1, "R5 deselected write ignored");

        // Partial command abandoned by deselect (R5)
        shift(32'h0, 4, j);
        cs_n = 1'b1;
        wait_n(HP);
        cs_n = 1'b0;
        wait_n(HP);
        do_read(6, "R5 resync after abort");

        // Stream two frames of channel 2, result changed mid frame (R8 R9)
        exp1 = {8'h40, conv_data[48 +: 24]};
        shift({24'h0, 8'h7A}, 8, j);
        r = '0;
        for (int i = 31; i >= 0; i--) begin
            if (i == 20) conv_data[48 +: 24] = 24'h13579B;
            bit_io(1'b0, o);
            r = {r[30:0], o};
        end
        chk(r === exp1, "R8 first frame captured at start", r, exp1);
        exp2 = {8'h40, 24'h13579B};
        shift(32'h1, 32, r);
        chk(r === exp2, "R9 stream continues on DIN low", r, exp2);
        do_read(1, "R9 stream exit on DIN high");

        // Broken run of ones: no reset (R7)
        do_write(1, 24'h0000A6);
        shift(32'h00, 8, j);
        shift(32'hFF, 8, j);
        shift(32'hFF, 8, j);
        shift(32'hFF, 8, j);
        shift(32'hFE, 8, j);
        do_read(1, "R7 31 ones do not reset");

        // Zero plus 32 ones: serial reset (R7)
        shift(32'h00, 8, j);
        shift(32'hFFFFFFFF, 32, j);
        model_defaults();
        read_sweep("R7 defaults after serial reset");

        chk(stab_bad == 0, "R3 dout stable while sclk high", stab_bad, 0);

        done = 1'b1;
        report();
        $finish;
    end
endmodule